// File: doc/BRIEF.md
# Descriptor Chain Fetch Unit

This unit loads the next link of a DMA channel's descriptor chain from memory. When it is asked to fetch, it reads four 32-bit words through a simple read master port. The words are a control word, a source address, a destination address and the address of the next descriptor, and they sit at byte offsets 0, 4, 8 and 12 from the chain head pointer. Once the fourth word arrives, the unit updates all of the channel's live fields in a single cycle. Those fields are the four transfer-mode flags, the total transfer size, the two addresses, the address of the descriptor that has just been loaded, and the link to the next one. A flag shows whether more descriptors follow.

The channel's transfer engine uses the "more follow" flag to decide whether a finished transfer chains to the next descriptor. The engine also reports completion back to this unit. If size write-back and descriptor mode are both enabled, the unit replaces the total-size field with the remaining word count.

The control word layout is: total size in bits [TOT_W-1:0] (bits [11:0] by default), increment-source at bit 16, increment-destination at bit 17, source-select at bit 18, destination-select at bit 19, and end-of-list at bit 20.

Top module: `descriptor_fetch_unit`

## Requirements
- R1: After reset, `busy`, `done`, `mem_req`, `more_follow` and every channel field output are zero.
- R2: A fetch issues exactly four reads, one at a time, at `chain_head`+0, +4, +8 and +12 in that order. `mem_req` and `mem_addr` hold steady until `mem_ack` accepts the read, and `mem_rdata` is taken in the cycle of `mem_ack`.
- R3: `done` is high for exactly one cycle, the cycle after the fourth read is accepted, and `busy` is low from that cycle on.
- R4: `ch_flags[0]`..`ch_flags[3]` take control word bits 16, 17, 18 and 19 (increment source, increment destination, source select, destination select).
- R5: `ch_total` takes control word bits [TOT_W-1:0]. No other size information is changed.
- R6: `ch_src` takes the second word and `ch_dst` takes the third word.
- R7: `more_follow` is the inverse of control word bit 20 (end of list).
- R8: `active_desc` takes the chain head used by the fetch, and `link_ptr` takes the fourth word.
- R9: A `fetch_req` while `busy` is high is ignored. No further reads follow the fourth, and the fields reflect the original head.
- R10: While idle, a `wb_strobe` with `wb_size_en` and `wb_desc_mode` both high sets `ch_total` to `ch_total - wb_count` one cycle later. If either enable is low, `ch_total` is unchanged.
- R11: During a fetch, every channel field output keeps its previous value until the cycle `done` is high. All fields then change together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | input | 1 | Start a descriptor fetch (ignored while busy) |
| chain_head | input | AW | Byte address of the descriptor to load, sampled with fetch_req |
| busy | output | 1 | A fetch is in progress |
| done | output | 1 | One-cycle pulse: the channel fields have been updated |
| mem_req | output | 1 | Read request |
| mem_addr | output | AW | Read byte address |
| mem_ack | input | 1 | Read accepted; mem_rdata valid in this cycle |
| mem_rdata | input | 32 | Read data |
| wb_strobe | input | 1 | Transfer completion report |
| wb_size_en | input | 1 | Size write-back enabled |
| wb_desc_mode | input | 1 | Channel runs in descriptor mode |
| wb_count | input | TOT_W | Words already transferred |
| ch_flags | output | 4 | {dst select, src select, inc dst, inc src} |
| ch_total | output | TOT_W | Total-size field |
| ch_src | output | AW | Source address |
| ch_dst | output | AW | Destination address |
| active_desc | output | AW | Address of the descriptor last loaded |
| link_ptr | output | AW | Next-descriptor pointer |
| more_follow | output | 1 | Chain continues after this descriptor |

## Verification
Every field result appears together with `done`, exactly one cycle after the memory accepts the fourth read. The bench counts rising edges and records the edge count at each accepted read, then requires that `done` is seen on the next count and not on the one after. A write-back takes effect one cycle after its strobe. All outputs are sampled on the falling edge, so no check competes with the register update. During slow memory responses, the bench also checks the outputs partway through a fetch to confirm that no field moves early.

// File: rtl/dfu_pkg.sv
package dfu_pkg;
    localparam int DESC_WORDS = 4;
    localparam int IDX_W      = $clog2(DESC_WORDS);
    localparam int NFLAG      = 4;

    typedef enum logic {
        FS_IDLE = 1'b0,
        FS_READ = 1'b1
    } fetch_state_e;
endpackage

// File: rtl/dfu_sequencer.sv
module dfu_sequencer
    import dfu_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fetch_req,
    input  logic [AW-1:0]    chain_head,
    input  logic             mem_ack,
    output logic             mem_req,
    output logic [AW-1:0]    mem_addr,
    output logic             beat,
    output logic             last_beat,
    output logic [IDX_W-1:0] word_idx,
    output logic [AW-1:0]    base,
    output logic             busy,
    output logic             done
);
    typedef struct packed {
        fetch_state_e     st;
        logic [IDX_W-1:0] idx;
        logic [AW-1:0]    base;
        logic             done;
    } seq_s;

    seq_s cur_q, nxt_d;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

    assign busy      = (cur_q.st == FS_READ);
    assign mem_req   = busy;
    assign mem_addr  = cur_q.base + AW'({cur_q.idx, 2'b00});
    assign beat      = busy && mem_ack;
    assign last_beat = beat && (cur_q.idx == LAST_IDX);
    assign word_idx  = cur_q.idx;
    assign base      = cur_q.base;
    assign done      = cur_q.done;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        unique case (cur_q.st)
            FS_IDLE: begin
                if (fetch_req) begin
                    nxt_d.st   = FS_READ;
                    nxt_d.idx  = '0;
                    nxt_d.base = chain_head;
                end
            end
            FS_READ: begin
                if (mem_ack) begin
                    if (cur_q.idx == LAST_IDX) begin
                        nxt_d.st   = FS_IDLE;
                        nxt_d.done = 1'b1;
                    end else begin
                        nxt_d.idx = cur_q.idx + 1'b1;
                    end
                end
            end
            default: nxt_d.st = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '{st: FS_IDLE, idx: '0, base: '0, done: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    head_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last_beat) |=> $stable(base));
endmodule

// File: rtl/dfu_field_stage.sv
module dfu_field_stage
    import dfu_pkg::*;
#(
    parameter int AW       = 32,
    parameter int TOT_W    = 12,
    parameter int FLAG_LSB = 16,
    parameter int EOL_BIT  = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat,
    input  logic             last_beat,
    input  logic [IDX_W-1:0] word_idx,
    input  logic [31:0]      rdata,
    input  logic [AW-1:0]    base,
    input  logic             idle,
    input  logic             wb_strobe,
    input  logic             wb_size_en,
    input  logic             wb_desc_mode,
    input  logic [TOT_W-1:0] wb_count,
    output logic [NFLAG-1:0] ch_flags,
    output logic [TOT_W-1:0] ch_total,
    output logic [AW-1:0]    ch_src,
    output logic [AW-1:0]    ch_dst,
    output logic [AW-1:0]    active_desc,
    output logic [AW-1:0]    link_ptr,
    output logic             more_follow
);
    typedef struct packed {
        logic [31:0]      stg_ctrl;
        logic [AW-1:0]    stg_src;
        logic [AW-1:0]    stg_dst;
        logic [NFLAG-1:0] flags;
        logic [TOT_W-1:0] total;
        logic [AW-1:0]    src;
        logic [AW-1:0]    dst;
        logic [AW-1:0]    active;
        logic [AW-1:0]    link;
        logic             more;
    } fld_s;

    fld_s fq, fd;
    logic [NFLAG-1:0] flag_pick;
    logic             wb_fire;

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        assign flag_pick[i] = fq.stg_ctrl[FLAG_LSB + i];
    end

    assign wb_fire = idle && wb_strobe && wb_size_en && wb_desc_mode;

    always_comb begin
        fd = fq;
        if (beat) begin
            unique case (word_idx)
                IDX_W'(0): fd.stg_ctrl = rdata;
                IDX_W'(1): fd.stg_src  = AW'(rdata);
                IDX_W'(2): fd.stg_dst  = AW'(rdata);
                default:   ;
            endcase
        end
        if (last_beat) begin
            fd.flags  = flag_pick;
            fd.total  = fq.stg_ctrl[TOT_W-1:0];
            fd.src    = fq.stg_src;
            fd.dst    = fq.stg_dst;
            fd.active = base;
            fd.link   = AW'(rdata);
            fd.more   = ~fq.stg_ctrl[EOL_BIT];
        end else if (wb_fire) begin
            fd.total  = fq.total - wb_count;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fq <= '0;
        end else begin
            fq <= fd;
        end
    end

    assign ch_flags    = fq.flags;
    assign ch_total    = fq.total;
    assign ch_src      = fq.src;
    assign ch_dst      = fq.dst;
    assign active_desc = fq.active;
    assign link_ptr    = fq.link;
    assign more_follow = fq.more;

    // R11
    fields_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !last_beat |=> ($stable(ch_src) && $stable(ch_dst) && $stable(link_ptr)
                        && $stable(active_desc) && $stable(ch_flags)));

    // R10
    total_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!last_beat && !wb_strobe) |=> $stable(ch_total));
endmodule

// File: rtl/descriptor_fetch_unit.sv
module descriptor_fetch_unit
    import dfu_pkg::*;
#(
    parameter int AW       = 32,
    parameter int TOT_W    = 12,
    parameter int FLAG_LSB = 16,
    parameter int EOL_BIT  = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fetch_req,
    input  logic [AW-1:0]    chain_head,
    output logic             busy,
    output logic             done,
    output logic             mem_req,
    output logic [AW-1:0]    mem_addr,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata,
    input  logic             wb_strobe,
    input  logic             wb_size_en,
    input  logic             wb_desc_mode,
    input  logic [TOT_W-1:0] wb_count,
    output logic [3:0]       ch_flags,
    output logic [TOT_W-1:0] ch_total,
    output logic [AW-1:0]    ch_src,
    output logic [AW-1:0]    ch_dst,
    output logic [AW-1:0]    active_desc,
    output logic [AW-1:0]    link_ptr,
    output logic             more_follow
);
    logic             beat_w;
    logic             last_w;
    logic [IDX_W-1:0] idx_w;
    logic [AW-1:0]    base_w;

    dfu_sequencer #(.AW(AW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_req  (fetch_req),
        .chain_head (chain_head),
        .mem_ack    (mem_ack),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .beat       (beat_w),
        .last_beat  (last_w),
        .word_idx   (idx_w),
        .base       (base_w),
        .busy       (busy),
        .done       (done)
    );

    dfu_field_stage #(
        .AW       (AW),
        .TOT_W    (TOT_W),
        .FLAG_LSB (FLAG_LSB),
        .EOL_BIT  (EOL_BIT)
    ) u_fields (
        .clk          (clk),
        .rst_n        (rst_n),
        .beat         (beat_w),
        .last_beat    (last_w),
        .word_idx     (idx_w),
        .rdata        (mem_rdata),
        .base         (base_w),
        .idle         (!busy),
        .wb_strobe    (wb_strobe),
        .wb_size_en   (wb_size_en),
        .wb_desc_mode (wb_desc_mode),
        .wb_count     (wb_count),
        .ch_flags     (ch_flags),
        .ch_total     (ch_total),
        .ch_src       (ch_src),
        .ch_dst       (ch_dst),
        .active_desc  (active_desc),
        .link_ptr     (link_ptr),
        .more_follow  (more_follow)
    );

    // R3
    done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(mem_ack) && $past(mem_req)));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);
endmodule

// File: tb/descriptor_fetch_unit_test.sv
module descriptor_fetch_unit_test;
    localparam int AW = 32;
    localparam int TW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fetch_req = 1'b0;
    logic [AW-1:0] chain_head = '0;
    logic          busy, done, mem_req, more_follow;
    logic [AW-1:0] mem_addr, ch_src, ch_dst, active_desc, link_ptr;
    logic          mem_ack = 1'b0;
    logic [31:0]   mem_rdata = '0;
    logic          wb_strobe = 1'b0, wb_size_en = 1'b0, wb_desc_mode = 1'b0;
    logic [TW-1:0] wb_count = '0;
    logic [3:0]    ch_flags;
    logic [TW-1:0] ch_total;

    descriptor_fetch_unit #(.AW(AW), .TOT_W(TW)) uut (
        .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .chain_head(chain_head),
        .busy(busy), .done(done), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .wb_strobe(wb_strobe),
        .wb_size_en(wb_size_en), .wb_desc_mode(wb_desc_mode), .wb_count(wb_count),
        .ch_flags(ch_flags), .ch_total(ch_total), .ch_src(ch_src), .ch_dst(ch_dst),
        .active_desc(active_desc), .link_ptr(link_ptr), .more_follow(more_follow)
    );

    always #10 clk = ~clk;

    typedef struct packed {
        logic [31:0] base;
        logic [31:0] w0;
        logic [31:0] w1;
        logic [31:0] w2;
        logic [31:0] w3;
        logic [1:0]  lat;
    } vec_t;

    localparam vec_t VEC [4] = '{
        '{base: 32'h40, w0: 32'h0001_0064, w1: 32'h0000_1000, w2: 32'h0000_2000, w3: 32'h80,        lat: 2'd0},
        '{base: 32'h80, w0: 32'h001A_0FFF, w1: 32'hDEAD_BEE0, w2: 32'h0000_0004, w3: 32'h0,         lat: 2'd2},
        '{base: 32'h10, w0: 32'h000F_0000, w1: 32'hFFFF_FFFC, w2: 32'h1234_5678, w3: 32'hC0,        lat: 2'd1},
        '{base: 32'hC4, w0: 32'h0010_0001, w1: 32'h0,         w2: 32'h1,         w3: 32'hFFFF_FFF0, lat: 2'd0}
    };

    logic [31:0] mem_words [0:63];
    logic [31:0] log_addr [0:7];
    int log_n = 0;
    int last_ack_cyc = 0;
    int cyc = 0;
    int lat = 0;
    int waitc = 0;
    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    // memory responder
    initial forever begin
        @(negedge clk);
        mem_ack = 1'b0;
        if (mem_req) begin
            if (waitc >= lat) begin
                mem_ack   = 1'b1;
                mem_rdata = mem_words[mem_addr[7:2]];
                if (log_n < 8) log_addr[log_n] = mem_addr;
                log_n++;
                last_ack_cyc = cyc;
                waitc = 0;
            end else begin
                waitc++;
            end
        end else begin
            waitc = 0;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load_desc(input vec_t v);
        mem_words[v.base[7:2]]              = v.w0;
        mem_words[v.base[7:2] + 6'd1]       = v.w1;
        mem_words[v.base[7:2] + 6'd2]       = v.w2;
        mem_words[v.base[7:2] + 6'd3]       = v.w3;
    endtask

    task automatic start_fetch(input logic [31:0] head, input int l);
        @(negedge clk);
        lat = l;
        log_n = 0;
        chain_head = head;
        fetch_req = 1'b1;
        @(negedge clk);
        fetch_req = 1'b0;
    endtask

    task automatic wait_done(output int done_cyc);
        done_cyc = -1;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (done) begin
                done_cyc = cyc;
                break;
            end
        end
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=%h expected=%h", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        int dc;
        for (int i = 0; i < 64; i++) mem_words[i] = 32'h0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy && !done && !mem_req && !more_follow, "R1 status", {busy, done, mem_req, more_follow}, 0);
        check(ch_flags == 0 && ch_total == 0, "R1 flags/total", {ch_flags, ch_total}, 0);
        check(ch_src == 0 && ch_dst == 0 && active_desc == 0 && link_ptr == 0, "R1 addresses",
              ch_src | ch_dst | active_desc | link_ptr, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // table of vectors
        for (int v = 0; v < 4; v++) begin
            load_desc(VEC[v]);
            start_fetch(VEC[v].base, int'(VEC[v].lat));
            wait_done(dc);
            check(dc == last_ack_cyc + 1, "R3 done timing", dc, last_ack_cyc + 1);
            check(log_n == 4, "R2 read count", log_n, 4);
            for (int k = 0; k < 4; k++)
                check(log_addr[k] == VEC[v].base + 32'(4 * k), "R2 read address", log_addr[k],
                      VEC[v].base + 32'(4 * k));
            check(!busy, "R3 busy low", busy, 0);
            check(ch_flags == VEC[v].w0[19:16], "R4 flags", ch_flags, VEC[v].w0[19:16]);
            check(ch_total == VEC[v].w0[11:0], "R5 total", ch_total, VEC[v].w0[11:0]);
            check(ch_src == VEC[v].w1, "R6 src", ch_src, VEC[v].w1);
            check(ch_dst == VEC[v].w2, "R6 dst", ch_dst, VEC[v].w2);
            check(more_follow == !VEC[v].w0[20], "R7 more", more_follow, !VEC[v].w0[20]);
            check(active_desc == VEC[v].base, "R8 active", active_desc, VEC[v].base);
            check(link_ptr == VEC[v].w3, "R8 link", link_ptr, VEC[v].w3);
            @(negedge clk);
            check(!done, "R3 single pulse", done, 0);
        end

        // R9: request during busy ignored
        load_desc(VEC[0]);
        load_desc(VEC[1]);
        start_fetch(VEC[0].base, 1);
        chain_head = VEC[1].base;
        fetch_req = 1'b1;
        @(negedge clk);
        @(negedge clk);
        fetch_req = 1'b0;
        wait_done(dc);
        check(active_desc == VEC[0].base, "R9 head kept", active_desc, VEC[0].base);
        check(ch_src == VEC[0].w1, "R9 fields from first head", ch_src, VEC[0].w1);
        repeat (5) @(negedge clk);
        check(log_n == 4 && !mem_req, "R9 no extra reads", log_n, 4);

        // R10: size write-back
        @(negedge clk);
        wb_count = 12'd30; wb_size_en = 1'b1; wb_desc_mode = 1'b1; wb_strobe = 1'b1;
        @(negedge clk);
        wb_strobe = 1'b0;
        check(ch_total == 12'd70, "R10 remaining count", ch_total, 70);
        wb_size_en = 1'b0; wb_strobe = 1'b1;
        @(negedge clk);
        wb_strobe = 1'b0;
        check(ch_total == 12'd70, "R10 size_en low no effect", ch_total, 70);
        wb_size_en = 1'b1; wb_desc_mode = 1'b0; wb_strobe = 1'b1;
        @(negedge clk);
        wb_strobe = 1'b0;
        check(ch_total == 12'd70, "R10 desc_mode low no effect", ch_total, 70);
        wb_size_en = 1'b0;

        // R11: fields frozen mid-fetch
        start_fetch(VEC[1].base, 2);
        wait (log_n == 2);
        #1;
        check(ch_src == VEC[0].w1 && ch_total == 12'd70 && more_follow, "R11 src/total held mid-fetch",
              ch_src, VEC[0].w1);
        check(link_ptr == VEC[0].w3 && active_desc == VEC[0].base, "R11 link held mid-fetch",
              link_ptr, VEC[0].w3);
        wait_done(dc);
        check(ch_src == VEC[1].w1 && ch_total == VEC[1].w0[11:0], "R11 update at done", ch_src, VEC[1].w1);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule